// File: doc/BRIEF.md
# Event-Delivery Exit Information Recorder

This block follows an interrupt or exception from the cycle its delivery through the vector table begins until the handler's first instruction is fetched. While that delivery window is open, it keeps a copy of the event. The copy holds the vector, the event class, whether an error code is pushed, the error code itself, and the instruction length. The length comes from the instruction that raised the event, or from the entry-supplied value when the event was injected at entry.

When a virtual-machine exit is signalled, the block latches three results:
- a 32-bit vectoring-information word;
- an error-code word;
- an instruction-length value.

The information word is marked valid only if the exit really happened during delivery. The window must be open, and the exit cause must not be one of the excluded classes: caused directly by the original event, caused directly by a resulting double fault, taken on the handler's first fetch, or a triple fault. Fields that have no defined value are driven to zero, so every output can be predicted.

Top module: `dlv_exit_recorder`

## Requirements
- R1: Information bits 7:0 hold the event vector. An NMI (type 2) always reports 2. Hardware and software exceptions (types 3 and 6) report only the low five bits of the supplied vector, so the value is at most 31. Every other type reports the vector unchanged.
- R2: Information bits 10:8 carry the event type exactly as recorded: 0 external interrupt, 2 NMI, 3 hardware exception, 4 software interrupt, 5 privileged software interrupt, 6 software exception.
- R3: Information bit 11 is 1 only when the type is 3 and the error-push flag was set. In that case the error-code output equals the recorded error code; otherwise the error-code output is 0.
- R4: A valid report has bit 31 set and bits 30:12 all zero.
- R5: The window opens on a delivery-start strobe and closes on a handler-fetch strobe or on reset. A start and a fetch in the same cycle leave it open. An exit taken while the window is closed reports an information word, error code and length that are all zero.
- R6: Exit causes 1 (direct), 2 (double-fault direct), 3 (handler first fetch) and 4 (triple fault) always report all-zero outputs, even with the window open. Only cause 0 (fault during delivery) can produce a valid report.
- R7: The length output carries the recorded 4-bit byte count for types 4, 5 and 6 and is 0 for all other types.
- R8: When the injected flag accompanies the delivery start, the recorded length is the entry-supplied length rather than the measured instruction length.
- R9: A delivery start while the window is already open, such as a nested fault, replaces the whole recorded event.
- R10: Outputs are zero after reset. They change only on the clock edge that samples an exit strobe, and they hold their values until the next exit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_start | input | 1 | Delivery of an event begins this cycle |
| dlv_vector | input | 8 | Vector number of the event |
| dlv_type | input | 3 | Event type code |
| dlv_err_push | input | 1 | Event would push an error code |
| dlv_err_code | input | 32 | Error code of the event |
| dlv_ilen | input | 4 | Measured length of the raising instruction |
| dlv_injected | input | 1 | Event was injected at entry |
| entry_len | input | 4 | Entry-supplied instruction length |
| handler_fetch | input | 1 | First fetch of the handler, closes the window |
| exit_strobe | input | 1 | Virtual-machine exit occurs this cycle |
| exit_cause | input | 3 | Exit cause class (0 during delivery, 1 to 4 excluded) |
| vect_info | output | 32 | Vectoring-information word |
| vect_err | output | 32 | Error-code word |
| exit_ilen | output | 4 | Reported instruction length |

## Verification
The packing is swept over every defined event type. The vectors used include 2, 31 and values above 31, so the test shows where the NMI override and the five-bit exception truncation apply and where the raw vector passes through. Each type is crossed with both settings of the error-push flag and of the injected flag. This shows that only hardware exceptions raise the error-code bit and that only the three software classes report a length, taken from the correct source. Separate sequences close the window with a handler fetch, try each excluded cause with the window open, nest a second delivery over a first, and fire new deliveries between exits. These separate the window, cause and hold rules from the packing itself.

// File: rtl/dlv_pkg.sv
package dlv_pkg;

   typedef enum logic [2:0] {
      EV_EXTINT = 3'd0,
      EV_NMI    = 3'd2,
      EV_HWEXC  = 3'd3,
      EV_SWINT  = 3'd4,
      EV_PSWINT = 3'd5,
      EV_SWEXC  = 3'd6
   } ev_type_e;

   typedef enum logic [2:0] {
      XC_IN_DELIVERY = 3'd0,
      XC_DIRECT      = 3'd1,
      XC_DF_DIRECT   = 3'd2,
      XC_HFETCH      = 3'd3,
      XC_TRIPLE      = 3'd4
   } exit_cause_e;

   localparam int unsigned TYPE_W = 3;

   // Classes whose length field is meaningful.
   function automatic logic is_soft(input logic [2:0] t);
      return (t == EV_SWINT) || (t == EV_PSWINT) || (t == EV_SWEXC);
   endfunction

   // Classes whose vector is an exception number.
   function automatic logic is_exc(input logic [2:0] t);
      return (t == EV_HWEXC) || (t == EV_SWEXC);
   endfunction

endpackage

// File: rtl/dlv_window.sv
module dlv_window
   import dlv_pkg::*;
#(
   parameter int unsigned VEC_W = 8,
   parameter int unsigned ERR_W = 32,
   parameter int unsigned LEN_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dlv_start,
   input  logic [VEC_W-1:0]   dlv_vector,
   input  logic [TYPE_W-1:0]  dlv_type,
   input  logic               dlv_err_push,
   input  logic [ERR_W-1:0]   dlv_err_code,
   input  logic [LEN_W-1:0]   dlv_ilen,
   input  logic               dlv_injected,
   input  logic [LEN_W-1:0]   entry_len,
   input  logic               handler_fetch,
   output logic               win_open,
   output logic [VEC_W-1:0]   rec_vec,
   output logic [TYPE_W-1:0]  rec_type,
   output logic               rec_push,
   output logic [ERR_W-1:0]   rec_err,
   output logic [LEN_W-1:0]   rec_len
);

   logic [LEN_W-1:0] len_src;

   // Entry-injected events report the length handed over at entry.
   assign len_src = dlv_injected ? entry_len : dlv_ilen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_open <= 1'b0;
      end else if (dlv_start) begin
         win_open <= 1'b1;
      end else if (handler_fetch) begin
         win_open <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_vec  <= '0;
         rec_type <= '0;
         rec_push <= 1'b0;
         rec_err  <= '0;
         rec_len  <= '0;
      end else if (dlv_start) begin
         rec_vec  <= dlv_vector;
         rec_type <= dlv_type;
         rec_push <= dlv_err_push;
         rec_err  <= dlv_err_code;
         rec_len  <= len_src;
      end
   end

endmodule

// File: rtl/dlv_pack.sv
module dlv_pack
   import dlv_pkg::*;
#(
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned ERR_W        = 32,
   parameter int unsigned LEN_W        = 4,
   parameter int unsigned INFO_W       = 32,
   parameter int unsigned NMI_VEC      = 2,
   parameter int unsigned EXC_VEC_BITS = 5,
   parameter bit          MASK_UNDEF   = 1'b1
)(
   input  logic               in_dlv,
   input  logic [VEC_W-1:0]   rec_vec,
   input  logic [TYPE_W-1:0]  rec_type,
   input  logic               rec_push,
   input  logic [ERR_W-1:0]   rec_err,
   input  logic [LEN_W-1:0]   rec_len,
   output logic [INFO_W-1:0]  info_d,
   output logic [ERR_W-1:0]   err_d,
   output logic [LEN_W-1:0]   len_d
);

   localparam int unsigned TYPE_LSB  = VEC_W;
   localparam int unsigned ERRV_BIT  = VEC_W + TYPE_W;
   localparam int unsigned VALID_BIT = INFO_W - 1;
   localparam logic [VEC_W-1:0] EXC_MASK = VEC_W'((1 << EXC_VEC_BITS) - 1);
   localparam logic [VEC_W-1:0] NMI_V    = VEC_W'(NMI_VEC);

   logic [VEC_W-1:0]  vec_f;
   logic              errv;
   logic [INFO_W-1:0] raw_info;
   logic [ERR_W-1:0]  raw_err;
   logic [LEN_W-1:0]  raw_len;

   always_comb begin
      if (rec_type == EV_NMI)
         vec_f = NMI_V;
      else if (is_exc(rec_type))
         vec_f = rec_vec & EXC_MASK;
      else
         vec_f = rec_vec;
   end

   assign errv = rec_push && (rec_type == EV_HWEXC);

   always_comb begin
      raw_info                        = '0;
      raw_info[VEC_W-1:0]             = vec_f;
      raw_info[TYPE_LSB +: TYPE_W]    = rec_type;
      raw_info[ERRV_BIT]              = errv;
      raw_info[VALID_BIT]             = 1'b1;
   end

   assign raw_err = errv ? rec_err : '0;
   assign raw_len = is_soft(rec_type) ? rec_len : '0;

   generate
      if (MASK_UNDEF) begin : g_mask
         assign info_d = in_dlv ? raw_info : '0;
         assign err_d  = in_dlv ? raw_err  : '0;
         assign len_d  = in_dlv ? raw_len  : '0;
      end else begin : g_raw
         always_comb begin
            info_d            = raw_info;
            info_d[VALID_BIT] = in_dlv;
         end
         assign err_d = raw_err;
         assign len_d = raw_len;
      end
   endgenerate

endmodule

// File: rtl/dlv_exit_recorder.sv
module dlv_exit_recorder
   import dlv_pkg::*;
#(
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned ERR_W        = 32,
   parameter int unsigned LEN_W        = 4,
   parameter int unsigned INFO_W       = 32,
   parameter int unsigned NMI_VEC      = 2,
   parameter int unsigned EXC_VEC_BITS = 5,
   parameter bit          MASK_UNDEF   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dlv_start,
   input  logic [VEC_W-1:0]  dlv_vector,
   input  logic [2:0]        dlv_type,
   input  logic              dlv_err_push,
   input  logic [ERR_W-1:0]  dlv_err_code,
   input  logic [LEN_W-1:0]  dlv_ilen,
   input  logic              dlv_injected,
   input  logic [LEN_W-1:0]  entry_len,
   input  logic              handler_fetch,
   input  logic              exit_strobe,
   input  logic [2:0]        exit_cause,
   output logic [INFO_W-1:0] vect_info,
   output logic [ERR_W-1:0]  vect_err,
   output logic [LEN_W-1:0]  exit_ilen
);

   generate
      if (INFO_W < VEC_W + TYPE_W + 2) begin : g_bad_info
         $error("INFO_W too narrow for vector, type, error flag and valid bit");
      end
      if (EXC_VEC_BITS > VEC_W) begin : g_bad_exc
         $error("EXC_VEC_BITS exceeds VEC_W");
      end
      if (LEN_W < 4) begin : g_bad_len
         $error("LEN_W must hold a 1 to 15 byte count");
      end
      if (NMI_VEC >= (1 << VEC_W)) begin : g_bad_nmi
         $error("NMI_VEC does not fit VEC_W");
      end
   endgenerate

   logic              win_open;
   logic [VEC_W-1:0]  rec_vec;
   logic [2:0]        rec_type;
   logic              rec_push;
   logic [ERR_W-1:0]  rec_err;
   logic [LEN_W-1:0]  rec_len;
   logic              in_dlv;
   logic [INFO_W-1:0] info_d;
   logic [ERR_W-1:0]  err_d;
   logic [LEN_W-1:0]  len_d;

   dlv_window #(
      .VEC_W (VEC_W),
      .ERR_W (ERR_W),
      .LEN_W (LEN_W)
   ) u_win (
      .clk           (clk),
      .rst_n         (rst_n),
      .dlv_start     (dlv_start),
      .dlv_vector    (dlv_vector),
      .dlv_type      (dlv_type),
      .dlv_err_push  (dlv_err_push),
      .dlv_err_code  (dlv_err_code),
      .dlv_ilen      (dlv_ilen),
      .dlv_injected  (dlv_injected),
      .entry_len     (entry_len),
      .handler_fetch (handler_fetch),
      .win_open      (win_open),
      .rec_vec       (rec_vec),
      .rec_type      (rec_type),
      .rec_push      (rec_push),
      .rec_err       (rec_err),
      .rec_len       (rec_len)
   );

   // Only a fault-during-delivery cause inside an open window qualifies.
   assign in_dlv = win_open && (exit_cause == XC_IN_DELIVERY);

   dlv_pack #(
      .VEC_W        (VEC_W),
      .ERR_W        (ERR_W),
      .LEN_W        (LEN_W),
      .INFO_W       (INFO_W),
      .NMI_VEC      (NMI_VEC),
      .EXC_VEC_BITS (EXC_VEC_BITS),
      .MASK_UNDEF   (MASK_UNDEF)
   ) u_pack (
      .in_dlv   (in_dlv),
      .rec_vec  (rec_vec),
      .rec_type (rec_type),
      .rec_push (rec_push),
      .rec_err  (rec_err),
      .rec_len  (rec_len),
      .info_d   (info_d),
      .err_d    (err_d),
      .len_d    (len_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vect_info <= '0;
         vect_err  <= '0;
         exit_ilen <= '0;
      end else if (exit_strobe) begin
         vect_info <= info_d;
         vect_err  <= err_d;
         exit_ilen <= len_d;
      end
   end

endmodule

// File: rtl/dlv_exit_chk.sv
module dlv_exit_chk #(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned ERR_W      = 32,
   parameter int unsigned LEN_W      = 4,
   parameter int unsigned INFO_W     = 32,
   parameter int unsigned NMI_VEC    = 2,
   parameter bit          MASK_UNDEF = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              exit_strobe,
   input logic [2:0]        exit_cause,
   input logic              win_open,
   input logic [INFO_W-1:0] vect_info,
   input logic [ERR_W-1:0]  vect_err,
   input logic [LEN_W-1:0]  exit_ilen
);

   localparam int unsigned VB = INFO_W - 1;

   logic [2:0] ty;
   assign ty = vect_info[VEC_W +: 3];

   a_r1_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (vect_info[VB] && ty == 3'd2) |-> (vect_info[VEC_W-1:0] == VEC_W'(NMI_VEC)));

   a_r3_errflag_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
      vect_info[VEC_W+3] |-> (ty == 3'd3));

   a_r3_err_zero_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !vect_info[VEC_W+3] |-> (vect_err == '0));

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      vect_info[VB] |-> (vect_info[VB-1:VEC_W+4] == '0));

   a_r5_closed_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_strobe && !win_open) |=> !vect_info[VB]);

   a_r7_len_soft_only: assert property (@(posedge clk) disable iff (!rst_n)
      (vect_info[VB] && exit_ilen != '0) |-> (ty >= 3'd4 && ty <= 3'd6));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !exit_strobe |=> ($stable(vect_info) && $stable(vect_err) && $stable(exit_ilen)));

   generate
      if (MASK_UNDEF) begin : g_zero_chk
         a_r6_excluded_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (exit_strobe && exit_cause != 3'd0) |=>
               (vect_info == '0 && vect_err == '0 && exit_ilen == '0));
      end
   endgenerate

endmodule

bind dlv_exit_recorder dlv_exit_chk #(
   .VEC_W      (VEC_W),
   .ERR_W      (ERR_W),
   .LEN_W      (LEN_W),
   .INFO_W     (INFO_W),
   .NMI_VEC    (NMI_VEC),
   .MASK_UNDEF (MASK_UNDEF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exit_strobe (exit_strobe),
   .exit_cause  (exit_cause),
   .win_open    (win_open),
   .vect_info   (vect_info),
   .vect_err    (vect_err),
   .exit_ilen   (exit_ilen)
);

// File: tb/tb_dlv_exit_recorder.sv
`timescale 1ns/1ps
module tb_dlv_exit_recorder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dlv_start, dlv_err_push, dlv_injected, handler_fetch, exit_strobe;
   logic [7:0]  dlv_vector;
   logic [2:0]  dlv_type, exit_cause;
   logic [31:0] dlv_err_code;
   logic [3:0]  dlv_ilen, entry_len;
   logic [31:0] vect_info, vect_err;
   logic [3:0]  exit_ilen;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dlv_exit_recorder dut (
      .clk(clk), .rst_n(rst_n), .dlv_start(dlv_start), .dlv_vector(dlv_vector),
      .dlv_type(dlv_type), .dlv_err_push(dlv_err_push), .dlv_err_code(dlv_err_code),
      .dlv_ilen(dlv_ilen), .dlv_injected(dlv_injected), .entry_len(entry_len),
      .handler_fetch(handler_fetch), .exit_strobe(exit_strobe), .exit_cause(exit_cause),
      .vect_info(vect_info), .vect_err(vect_err), .exit_ilen(exit_ilen)
   );

   // Expected packing, worked out from R1..R4, R7 and R8.
   function automatic logic [31:0] exp_info(input logic [2:0] t, input logic [7:0] v,
                                            input logic push);
      logic [7:0] vv;
      logic       ev;
      if (t == 3'd2) vv = 8'd2;
      else if (t == 3'd3 || t == 3'd6) vv = v % 32;
      else vv = v;
      ev = push && (t == 3'd3);
      return 32'h8000_0000 + (32'(ev) * 2048) + (32'(t) * 256) + 32'(vv);
   endfunction

   function automatic logic [3:0] exp_len(input logic [2:0] t, input logic inj,
                                          input logic [3:0] il, input logic [3:0] el);
      if (t >= 3'd4 && t <= 3'd6) return inj ? el : il;
      return 4'd0;
   endfunction

   task automatic check(input string req, input logic [31:0] ei, input logic [31:0] ee,
                        input logic [3:0] el);
      checks++;
      if (vect_info !== ei || vect_err !== ee || exit_ilen !== el) begin
         fails++;
         $display("FAIL %s: info=%h err=%h len=%0d expected info=%h err=%h len=%0d",
                  req, vect_info, vect_err, exit_ilen, ei, ee, el);
      end
   endtask

   task automatic start(input logic [2:0] t, input logic [7:0] v, input logic push,
                        input logic [31:0] code, input logic [3:0] il, input logic inj,
                        input logic [3:0] el);
      dlv_start = 1'b1; dlv_type = t; dlv_vector = v; dlv_err_push = push;
      dlv_err_code = code; dlv_ilen = il; dlv_injected = inj; entry_len = el;
      @(negedge clk);
      dlv_start = 1'b0;
   endtask

   task automatic fetch();
      handler_fetch = 1'b1;
      @(negedge clk);
      handler_fetch = 1'b0;
   endtask

   task automatic do_exit(input logic [2:0] cause);
      exit_strobe = 1'b1; exit_cause = cause;
      @(negedge clk);
      exit_strobe = 1'b0; exit_cause = 3'd0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] types [6] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
      logic [7:0] vecs  [6] = '{8'd0, 8'd2, 8'd3, 8'd31, 8'd45, 8'd200};
      rst_n = 1'b0; dlv_start = 0; dlv_err_push = 0; dlv_injected = 0;
      handler_fetch = 0; exit_strobe = 0; dlv_vector = 0; dlv_type = 0;
      exit_cause = 0; dlv_err_code = 0; dlv_ilen = 0; entry_len = 0;
      repeat (3) @(negedge clk);
      #1 check("R10 reset state", 32'h0, 32'h0, 4'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R7 R8: sweep of the packing
      for (int ti = 0; ti < 6; ti++)
         for (int vi = 0; vi < 6; vi++)
            for (int p = 0; p < 2; p++)
               for (int inj = 0; inj < 2; inj++) begin
                  logic [31:0] code;
                  logic [3:0]  il, el;
                  logic [31:0] ei;
                  code = 32'hA500_0000 + 32'(ti * 97 + vi * 13 + p * 5 + inj);
                  il   = 4'(1 + ((ti + vi) % 15));
                  el   = 4'(15 - ((ti + vi + p) % 14));
                  start(types[ti], vecs[vi], p[0], code, il, inj[0], el);
                  do_exit(3'd0);
                  ei = exp_info(types[ti], vecs[vi], p[0]);
                  check("R1 R2 R3 R4 R7 R8 packing", ei,
                        (p == 1 && types[ti] == 3'd3) ? code : 32'h0,
                        exp_len(types[ti], inj[0], il, el));
                  fetch();
               end

      // R5: closed window after handler fetch
      start(3'd3, 8'd14, 1'b1, 32'h1234, 4'd3, 1'b0, 4'd0);
      fetch();
      do_exit(3'd0);
      check("R5 exit after handler fetch", 32'h0, 32'h0, 4'd0);

      // R5: start and fetch in the same cycle keep the window open
      dlv_start = 1'b1; handler_fetch = 1'b1; dlv_type = 3'd4; dlv_vector = 8'h80;
      dlv_err_push = 1'b0; dlv_ilen = 4'd2; dlv_injected = 1'b0;
      @(negedge clk);
      dlv_start = 1'b0; handler_fetch = 1'b0;
      do_exit(3'd0);
      check("R5 start wins over fetch", exp_info(3'd4, 8'h80, 1'b0), 32'h0, 4'd2);
      fetch();

      // R6: each excluded cause with an open window
      for (int c = 1; c <= 4; c++) begin
         start(3'd6, 8'd3, 1'b0, 32'h0, 4'd1, 1'b0, 4'd0);
         do_exit(3'(c));
         check("R6 excluded cause", 32'h0, 32'h0, 4'd0);
         fetch();
      end

      // R9: nested delivery replaces the record
      start(3'd3, 8'd13, 1'b1, 32'hDEAD, 4'd5, 1'b0, 4'd0);
      start(3'd3, 8'd8, 1'b1, 32'h0000_0000, 4'd7, 1'b0, 4'd0);
      do_exit(3'd0);
      check("R9 nested replaces", exp_info(3'd3, 8'd8, 1'b1), 32'h0, 4'd0);
      start(3'd0, 8'd99, 1'b0, 32'h0, 4'd1, 1'b0, 4'd0);
      do_exit(3'd0);
      check("R9 nested into external", exp_info(3'd0, 8'd99, 1'b0), 32'h0, 4'd0);
      fetch();

      // R10: outputs hold across deliveries between exits
      start(3'd5, 8'd7, 1'b0, 32'h0, 4'd9, 1'b1, 4'd11);
      do_exit(3'd0);
      check("R10 capture", exp_info(3'd5, 8'd7, 1'b0), 32'h0, 4'd11);
      fetch();
      start(3'd3, 8'd14, 1'b1, 32'hFFFF, 4'd2, 1'b0, 4'd0);
      repeat (3) @(negedge clk);
      #1 check("R10 hold without exit", exp_info(3'd5, 8'd7, 1'b0), 32'h0, 4'd11);
      do_exit(3'd0);
      check("R10 next exit updates", exp_info(3'd3, 8'd14, 1'b1), 32'hFFFF, 4'd0);

      // R5: reset closes the window
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_exit(3'd0);
      check("R5 reset closes window", 32'h0, 32'h0, 4'd0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule